// File: doc/BRIEF.md
# Program/Erase Status Readout Generator

This block supplies what a host sees on the data bus while an internal program or erase operation is running. Before an operation starts, the operation engine loads the word to be written and says whether the job is a program or an erase. The block stores both. While the engine's busy signal is high, every read returns a status word instead of array contents. Bit 7 of that word is a polling bit. Bit 6 is a toggle bit that changes on each new read access. When busy drops, reads go back to returning the array word that comes in on `arrayData`.

The block also drives the active-low ready/busy pad as an open-drain enable. While busy, the pad is pulled low. Otherwise it floats, and an external pull-up supplies the high level. Reads are marked by a combined active-low strobe: chip select and output enable both asserted. A read access begins on each falling edge of this strobe. All state is cleared by the asynchronous reset.

Top module: `flash_poll_status`

## Requirements
- R1: During a program operation (the loaded operation kind is program, `loadErase`=0), bit 7 of `rdData` and `statDq7` equal the inverse of bit 7 of the last loaded word.
- R2: During an erase operation (`loadErase`=1), bit 7 of `rdData` and `statDq7` read 0.
- R3: While busy, each falling edge of `rdStrobeN` inverts bit 6 of the status word. The toggle is 0 when idle, so the k-th read access of an operation shows bit 6 equal to k mod 2. The toggle returns to 0 one clock after busy is seen low.
- R4: Holding `rdStrobeN` low across several clocks, with no new falling edge, leaves bit 6 unchanged.
- R5: While the status word is shown, every `rdData` bit other than bits 7 and 6 reads 0.
- R6: The status word is shown from the clock after `busy` is seen high. From the clock after `busy` is seen low, `rdData` equals `arrayData`.
- R7: `rybyDriveLow` goes to 1 on the clock after `busy` is seen high and to 0 on the clock after `busy` is seen low. A value of 1 pulls the pad low.
- R8: A load pulse (`loadValid`=1) that arrives while the status word is shown is ignored. Both the stored word and the stored operation kind stay unchanged.
- R9: While `rst_n` is low, `rybyDriveLow` is 0, `statDq6` is 0 and `rdData` equals `arrayData`. This holds without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdStrobeN | input | 1 | Combined chip-select and output-enable read strobe, active low |
| busy | input | 1 | Operation engine is running a program or erase |
| loadValid | input | 1 | Capture `loadData` and `loadErase` |
| loadErase | input | 1 | Operation kind: 1 = erase, 0 = program |
| loadData | input | DATA_W | Last word loaded for the operation |
| arrayData | input | DATA_W | Word read from the array |
| rdData | output | DATA_W | Word returned to the host |
| statDq7 | output | 1 | Polling status bit |
| statDq6 | output | 1 | Toggle status bit |
| rybyDriveLow | output | 1 | Open-drain enable for the ready/busy pad |

## Verification
On every cycle, the assertions check the following. The pad enable tracks busy with a one-clock lag. The toggle flips on every accepted read start and is held at zero while idle. The stored word cannot change while status is shown. The polling value under program and erase, the k mod 2 toggle sequence across separate reads, and the return to array data all depend on stimulus order and data values. Only the bench's sweeps show these, along with the ignored loads and the asynchronous reset in the middle of an operation.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic captureLoad;  // store loaded word and operation kind
    logic flipToggle;   // a read access began while busy
    logic clearToggle;  // idle: hold toggle at zero
    logic showStatus;   // return status word instead of array data
  } statusStrobes_t;
endpackage

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import flash_status_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rdStrobeN,
  input  logic           busy,
  input  logic           loadValid,
  output statusStrobes_t strobes,
  output logic           rybyDriveLow
);
  logic busyQ;
  logic strobeQ;
  logic readStart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ   <= 1'b0;
      strobeQ <= 1'b1;
    end else begin
      busyQ   <= busy;
      strobeQ <= rdStrobeN;
    end
  end

  // Falling edge of the combined strobe starts a read access.
  assign readStart = strobeQ & ~rdStrobeN;

  always_comb begin
    strobes.captureLoad = loadValid & ~busyQ;
    strobes.flipToggle  = readStart & busyQ;
    strobes.clearToggle = ~busyQ;
    strobes.showStatus  = busyQ;
  end

  assign rybyDriveLow = busyQ;

  assert_ryby_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rybyDriveLow);
  assert_ryby_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !rybyDriveLow);
  assert_toggle_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.flipToggle, strobes.clearToggle}));
endmodule

// File: rtl/poll_datapath.sv
module poll_datapath
  import flash_status_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  statusStrobes_t    strobes,
  input  logic              loadErase,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              statDq7,
  output logic              statDq6
);
  logic [DATA_W-1:0] lastWordQ;
  logic              eraseQ;
  logic              toggleQ;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastWordQ <= '1;
      eraseQ    <= 1'b0;
    end else if (strobes.captureLoad) begin
      lastWordQ <= loadData;
      eraseQ    <= loadErase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  toggleQ <= 1'b0;
    else if (strobes.clearToggle) toggleQ <= 1'b0;
    else if (strobes.flipToggle)  toggleQ <= ~toggleQ;
  end

  // Erase polls as 0; program polls as the inverse of the loaded bit.
  assign statDq7 = eraseQ ? 1'b0 : ~lastWordQ[POLL_BIT];
  assign statDq6 = toggleQ;

  for (genvar i = 0; i < DATA_W; i++) begin : gStatus
    if (i == POLL_BIT) begin : gPoll
      assign statusWord[i] = statDq7;
    end else if (i == TOGGLE_BIT) begin : gTog
      assign statusWord[i] = statDq6;
    end else begin : gZero
      assign statusWord[i] = 1'b0;
    end
  end

  assign rdData = strobes.showStatus ? statusWord : arrayData;

  assert_toggle_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flipToggle |=> (toggleQ != $past(toggleQ)));
  assert_toggle_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearToggle |=> !toggleQ);
  assert_load_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.showStatus |=> ($stable(lastWordQ) && $stable(eraseQ)));
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_status_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStrobeN,
  input  logic              busy,
  input  logic              loadValid,
  input  logic              loadErase,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              statDq7,
  output logic              statDq6,
  output logic              rybyDriveLow
);
  statusStrobes_t strobes;

  poll_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .rdStrobeN(rdStrobeN), .busy(busy),
    .loadValid(loadValid), .strobes(strobes), .rybyDriveLow(rybyDriveLow)
  );

  poll_datapath #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .loadErase(loadErase),
    .loadData(loadData), .arrayData(arrayData), .rdData(rdData),
    .statDq7(statDq7), .statDq6(statDq6)
  );
endmodule

// File: tb/tb_flash_poll_status.sv
module tb_flash_poll_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdStrobeN = 1'b1;
  logic busy = 1'b0;
  logic loadValid = 1'b0;
  logic loadErase = 1'b0;
  logic [15:0] loadData = '0;
  logic [15:0] arrayData = '0;
  logic [15:0] rdData;
  logic statDq7, statDq6, rybyDriveLow;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  flash_poll_status dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Load a word and an operation kind while idle.
  task automatic load(input logic [15:0] w, input logic er);
    loadData = w; loadErase = er; loadValid = 1'b1;
    step();
    loadValid = 1'b0;
  endtask

  function automatic logic [15:0] statusOf(input logic [15:0] w, input logic er, input logic t);
    logic [15:0] s = '0;
    s[7] = er ? 1'b0 : ~w[7];
    s[6] = t;
    return s;
  endfunction

  initial begin
    step(); step();
    // R9: reset state, asynchronous.
    arrayData = 16'h5A3C; busy = 1'b1; #1;
    chk("R9 ryby in reset", {15'd0, rybyDriveLow}, 16'd0);
    chk("R9 rdData in reset", rdData, 16'h5A3C);
    busy = 1'b0;
    rst_n = 1'b1;
    step();

    for (int w = 0; w < 24; w++) begin
      for (int er = 0; er < 2; er++) begin
        logic [15:0] word = 16'((w * 8191 + 53) ^ (w << 7));
        logic [15:0] arr  = 16'(w * 4099 + er * 777 + 1);
        logic [15:0] junk = ~word;
        arrayData = arr;
        load(word, er[0]);
        busy = 1'b1;
        step();
        chk("R7 ryby low while busy", {15'd0, rybyDriveLow}, 16'd1);
        chk(er ? "R2 erase status" : "R1 program status", rdData, statusOf(word, er[0], 1'b0));
        // R8: load during busy ignored.
        loadData = junk; loadErase = ~er[0]; loadValid = 1'b1;
        step();
        loadValid = 1'b0;
        chk("R8 load ignored while busy", rdData, statusOf(word, er[0], 1'b0));
        for (int k = 1; k <= 4; k++) begin
          rdStrobeN = 1'b0;
          step();
          chk("R3 toggle per read", rdData, statusOf(word, er[0], k[0]));
          chk("R5 other bits zero", rdData & 16'hFF3F, 16'h0000);
          chk(er ? "R2 dq7 erase" : "R1 dq7 program", {15'd0, statDq7}, {15'd0, (er ? 1'b0 : ~word[7])});
          if (k == 3) begin
            step(); step();
            chk("R4 held strobe no toggle", {15'd0, statDq6}, {15'd0, k[0]});
          end
          rdStrobeN = 1'b1;
          step();
        end
        busy = 1'b0;
        chk("R6 status until busy sampled", rdData, statusOf(word, er[0], 1'b0));
        step();
        chk("R6 array data after busy", rdData, arr);
        chk("R7 ryby released", {15'd0, rybyDriveLow}, 16'd0);
        chk("R3 toggle idle zero", {15'd0, statDq6}, 16'd0);
        rdStrobeN = 1'b0;
        step();
        chk("R3 no toggle when idle", {15'd0, statDq6}, 16'd0);
        rdStrobeN = 1'b1;
        step();
      end
    end

    // R9: reset in the middle of an operation.
    arrayData = 16'hC0DE;
    load(16'h0000, 1'b0);
    busy = 1'b1;
    step();
    rdStrobeN = 1'b0; step(); rdStrobeN = 1'b1; step();
    chk("R3 toggle before reset", {15'd0, statDq6}, 16'd1);
    rst_n = 1'b0; #1;
    chk("R9 ryby released by reset", {15'd0, rybyDriveLow}, 16'd0);
    chk("R9 toggle cleared by reset", {15'd0, statDq6}, 16'd0);
    chk("R9 array data in reset", rdData, 16'hC0DE);
    busy = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk("R9 idle after reset", rdData, 16'hC0DE);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule